// File: doc/BRIEF.md
# Length-Fitting FIFO Data Window

This block sits behind the command decoder of a function-1 slave port and serves its two data FIFOs through an address window. Each request arrives already decoded: direction, function number, register address, byte count, and a flag that marks a single-byte register-style access. A read request streams bytes out of an internal transmit FIFO. The slave logic loads that FIFO. A write request pushes bytes into an internal receive FIFO, which the slave logic drains.

The number of bytes moved is fixed by the request alone. It does not depend on how much data the FIFOs can supply or absorb. A read that runs past the end of the transmit data is padded with zero bytes. A write that overflows the receive FIFO keeps accepting bytes and discards the excess. Either way the host always sees exactly the length it asked for. Every byte moves under a valid/ready handshake. When a transfer completes, the block raises a one-cycle done pulse. A request the window does not serve is rejected with a one-cycle error pulse.

Top module: `lenfit_fifo_port`

## Requirements
- R1: A request whose function number is not 1 gives an `err` pulse on the cycle after it is accepted. It moves no data: `rd_valid` and `wr_ready` stay low, and both FIFOs keep their contents.
- R2: The window spans addresses 0x090 to 0x1F7FF inclusive, and every address in it reaches the same pair of FIFOs. A request at 0x08F or at 0x1F800 is rejected in the same way as in R1.
- R3: A single-byte access (`req_single`=1) moves exactly one byte, whatever the value of `req_count`.
- R4: A multi-byte access moves exactly `req_count` bytes. A multi-byte access with `req_count`=0 is rejected in the same way as in R1.
- R5: A read returns the transmit FIFO bytes in the order they were pushed. Once that FIFO is empty, each further requested byte is returned as 0x00, and padding bytes do not remove data from the FIFO.
- R6: A write stores the bytes it receives into the receive FIFO, in order, while the FIFO has room. While the FIFO is full, `wr_ready` stays high and each byte it accepts is dropped.
- R7: `done` is high for exactly one cycle, on the cycle after the handshake of the last requested byte. `req_ready` is high again in that same cycle.
- R8: Each FIFO holds DEPTH bytes and shows its full and empty flags to the slave side. A push into a full transmit FIFO is ignored, and so is a pop from an empty receive FIFO.
- R9: After reset the block is idle with `req_ready`=1. Both FIFOs are empty and not full, and `done`, `err`, `rd_valid` and `wr_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = host writes into the receive FIFO, 0 = host reads from the transmit FIFO |
| req_single | input | 1 | 1 = single-byte register-style access |
| req_func | input | 3 | Function number |
| req_addr | input | ADDR_W | Register address |
| req_count | input | CNT_W | Byte count of a multi-byte access |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte (0x00 when padding) |
| wr_valid | input | 1 | Host write byte present |
| wr_ready | output | 1 | Block takes the write byte |
| wr_data | input | 8 | Host write byte |
| done | output | 1 | One-cycle pulse after the last byte |
| err | output | 1 | One-cycle pulse for a rejected request |
| tx_push | input | 1 | Slave pushes a byte into the transmit FIFO |
| tx_data | input | 8 | Byte to push |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Slave pops a byte from the receive FIFO |
| rx_data | output | 8 | Head byte of the receive FIFO |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |

## Verification
A wrong remaining-byte count makes `done` arrive one or more cycles early or late. It also leaves `rd_valid` or `wr_ready` high past the requested length, so the error appears at the ports within the transfer that caused it. A bad transmit pointer shows up as a wrong or repeated byte, or as padding that starts too early, on the very next read handshake. A bad receive pointer shows up when the slave drains the FIFO after a write, either as wrong byte order or as a flag that disagrees with the number of bytes actually stored. A request decode fault shows up in the cycle after acceptance, as a missing or spurious `err` pulse.

// File: rtl/lenfit_fifo_port.sv
module lenfit_fifo_port #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 9,
  parameter logic [ADDR_W-1:0] WIN_LO = 'h00090,
  parameter logic [ADDR_W-1:0] WIN_HI = 'h1F7FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_single,
  input  logic [2:0]        req_func,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              done,
  output logic              err,
  input  logic              tx_push,
  input  logic [7:0]        tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_pop,
  output logic [7:0]        rx_data,
  output logic              rx_full,
  output logic              rx_empty
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;
  state_t           state;
  logic [CNT_W-1:0] rem;

  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];
  logic [AW:0] tx_wp, tx_rp, rx_wp, rx_rp;

  assign tx_empty = (tx_wp == tx_rp);
  assign tx_full  = (tx_wp[AW] != tx_rp[AW]) && (tx_wp[AW-1:0] == tx_rp[AW-1:0]);
  assign rx_empty = (rx_wp == rx_rp);
  assign rx_full  = (rx_wp[AW] != rx_rp[AW]) && (rx_wp[AW-1:0] == rx_rp[AW-1:0]);
  assign rx_data  = rx_mem[rx_rp[AW-1:0]];

  assign req_ready = (state == S_IDLE);
  assign rd_valid  = (state == S_RD);
  assign wr_ready  = (state == S_WR);
  assign rd_data   = tx_empty ? 8'h00 : tx_mem[tx_rp[AW-1:0]];

  wire rd_fire = rd_valid && rd_ready;
  wire wr_fire = wr_valid && wr_ready;
  wire last    = (rem == CNT_W'(1));
  wire take    = req_valid && req_ready;
  wire bad     = (req_func != 3'd1) || (req_addr < WIN_LO) || (req_addr > WIN_HI)
               || (!req_single && req_count == '0);

  wire tx_wen = tx_push && !tx_full;
  wire tx_ren = rd_fire && !tx_empty;
  wire rx_wen = wr_fire && !rx_full;
  wire rx_ren = rx_pop && !rx_empty;

  always_ff @(posedge clk) begin
    if (tx_wen) tx_mem[tx_wp[AW-1:0]] <= tx_data;
    if (rx_wen) rx_mem[rx_wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
      rx_wp <= '0;
      rx_rp <= '0;
    end else begin
      if (tx_wen) tx_wp <= tx_wp + 1'b1;
      if (tx_ren) tx_rp <= tx_rp + 1'b1;
      if (rx_wen) rx_wp <= rx_wp + 1'b1;
      if (rx_ren) rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rem   <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE:
          if (take) begin
            if (bad) err <= 1'b1;
            else begin
              rem   <= req_single ? CNT_W'(1) : req_count;
              state <= req_write ? S_WR : S_RD;
            end
          end
        default:
          if (rd_fire || wr_fire) begin
            rem <= rem - 1'b1;
            if (last) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
      endcase
    end
  end
endmodule

// File: rtl/lenfit_fifo_port_chk.sv
module lenfit_fifo_port_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic rd_ready,
  input logic wr_valid,
  input logic wr_ready,
  input logic done,
  input logic err,
  input logic tx_push,
  input logic tx_full,
  input logic tx_empty,
  input logic rx_pop,
  input logic rx_full,
  input logic rx_empty
);
  a_r1_err_moves_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rd_valid && !wr_ready && req_ready));
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready));
  a_r5_pad_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && tx_empty && !tx_push) |=> tx_empty);
  a_r6_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rx_full && !rx_pop) |=> rx_full);
  a_r8_tx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));
  a_r8_rx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty));
endmodule

bind lenfit_fifo_port lenfit_fifo_port_chk u_chk (.*);

// File: tb/lenfit_fifo_port_test.sv
module lenfit_fifo_port_test;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_single = 0;
  logic [2:0] req_func = 0;
  logic [16:0] req_addr = 0;
  logic [8:0] req_count = 0;
  logic rd_ready = 0, wr_valid = 0, tx_push = 0, rx_pop = 0;
  logic [7:0] wr_data = 0, tx_data = 0;
  logic req_ready, rd_valid, wr_ready, done, err;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0] rd_data, rx_data;

  lenfit_fifo_port #(.DEPTH(DEPTH)) uut (.*);

  int total = 0, bad = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] seed = 8'h40;

  // fields: [14] write, [13] single, [12:4] count, [3:0] tx bytes to preload
  localparam logic [14:0] VEC [0:6] = '{
    {1'b0, 1'b0, 9'd3,  4'd3},
    {1'b0, 1'b0, 9'd6,  4'd2},
    {1'b0, 1'b1, 9'd5,  4'd4},
    {1'b0, 1'b0, 9'd4,  4'd0},
    {1'b1, 1'b0, 9'd5,  4'd0},
    {1'b1, 1'b1, 9'd9,  4'd0},
    {1'b1, 1'b0, 9'd10, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] v);
    @(negedge clk);
    tx_data = v; tx_push = 1;
    @(posedge clk); #1 tx_push = 0;
    if (txq.size() < DEPTH) txq.push_back(v);
  endtask

  task automatic issue(input bit wr, input bit sg, input logic [8:0] cnt,
                       input logic [16:0] ad, input logic [2:0] fn);
    @(negedge clk);
    req_write = wr; req_single = sg; req_count = cnt; req_addr = ad; req_func = fn;
    req_valid = 1;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic xfer(input bit wr, input bit sg, input logic [8:0] cnt,
                      input logic [16:0] ad, input string tag);
    int n = sg ? 1 : int'(cnt);
    issue(wr, sg, cnt, ad, 3'd1);
    if (wr) begin
      wr_valid = 1;
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        chk(wr_ready && !done, {tag, " R6 wr_ready"}, wr_ready, 1);
        wr_data = seed;
        if (rxq.size() < DEPTH) rxq.push_back(seed);
        seed++;
      end
      @(negedge clk); wr_valid = 0;
      chk(done && req_ready && !wr_ready, {tag, " R7 done after write"}, done, 1);
    end else begin
      rd_ready = 1;
      for (int i = 0; i < n; i++) begin
        logic [7:0] e;
        e = (txq.size() > 0) ? txq.pop_front() : 8'h00;
        @(negedge clk);
        chk(rd_valid && rd_data == e, {tag, " R5 read byte"}, rd_data, e);
      end
      @(negedge clk);
      chk(done && req_ready && !rd_valid, {tag, " R7 done after read"}, done, 1);
      rd_ready = 0;
    end
    @(negedge clk);
    chk(!done, {tag, " R7 done single cycle"}, done, 0);
  endtask

  task automatic drain_rx(input string tag);
    while (rxq.size() > 0) begin
      logic [7:0] e;
      e = rxq.pop_front();
      @(negedge clk);
      chk(!rx_empty && rx_data == e, {tag, " R6 rx byte"}, rx_data, e);
      rx_pop = 1;
      @(posedge clk); #1 rx_pop = 0;
    end
    @(negedge clk);
    chk(rx_empty && !rx_full, {tag, " R8 rx empty after drain"}, rx_empty, 1);
  endtask

  task automatic rejected(input bit wr, input bit sg, input logic [8:0] cnt,
                          input logic [16:0] ad, input logic [2:0] fn, input string tag);
    issue(wr, sg, cnt, ad, fn);
    @(negedge clk);
    chk(err && !rd_valid && !wr_ready, {tag, " err pulse"}, err, 1);
    @(negedge clk);
    chk(!err && req_ready && !rd_valid && !wr_ready, {tag, " err ends idle"}, err, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready && tx_empty && rx_empty && !tx_full && !rx_full && !done && !err
        && !rd_valid && !wr_ready, "R9 reset state", 0, 1);

    foreach (VEC[k]) begin
      for (int j = 0; j < int'(VEC[k][3:0]); j++) push_tx(seed++);
      xfer(VEC[k][14], VEC[k][13], VEC[k][12:4], 17'h00100,
           VEC[k][13] ? "R3 vec" : "R4 vec");
      if (VEC[k][14]) drain_rx("vec");
    end

    push_tx(8'h5A);
    rejected(1'b0, 1'b0, 9'd2, 17'h00100, 3'd0, "R1 func0 read");
    rejected(1'b1, 1'b0, 9'd2, 17'h00100, 3'd2, "R1 func2 write");
    rejected(1'b0, 1'b0, 9'd1, 17'h0008F, 3'd1, "R2 below window");
    rejected(1'b0, 1'b0, 9'd1, 17'h1F800, 3'd1, "R2 above window");
    rejected(1'b0, 1'b0, 9'd0, 17'h00100, 3'd1, "R4 zero count");
    chk(rx_empty, "R1 rx untouched", rx_empty, 1);
    xfer(1'b0, 1'b1, 9'd0, 17'h00090, "R2 low edge");
    push_tx(8'h6B);
    xfer(1'b0, 1'b0, 9'd2, 17'h1F7FF, "R2 high edge");

    for (int j = 0; j < DEPTH; j++) push_tx(8'h80 + 8'(j));
    @(negedge clk);
    chk(tx_full && !tx_empty, "R8 tx full", tx_full, 1);
    push_tx(8'hEE);
    xfer(1'b0, 1'b0, 9'(DEPTH + 1), 17'h00200, "R8 full push ignored");

    @(negedge clk); rx_pop = 1;
    @(posedge clk); #1 rx_pop = 0;
    xfer(1'b1, 1'b0, 9'd2, 17'h00300, "R8 empty pop ignored");
    drain_rx("R8");

    xfer(1'b1, 1'b0, 9'(DEPTH + 3), 17'h01000, "R6 overflow");
    @(negedge clk);
    chk(rx_full, "R6 rx full after overflow", rx_full, 1);
    drain_rx("R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R7 act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule